// File: doc/BRIEF.md
# Status Register and Write Protection Unit

This block is the permission keeper of a serial nonvolatile memory. It holds the status byte: a write-enable latch, a busy flag, a two-bit block-lock code and a hardware-protect enable. It also rules on every write that the command front end wants to start. The front end sends single-cycle strobes. One sets or clears the enable latch. One stages a new status value. One asks to commit the staged status value. One asks to commit an array write at a given address. The unit answers each commit request with a registered grant or deny pulse one cycle later.

A granted write sets the busy flag until the write timer returns a done pulse. While the busy flag is set the status byte reads as all ones. When the done pulse arrives, the enable latch is cleared. If the finished write was a status write, the staged lock and protect-enable bits are copied into the nonvolatile fields at the same moment.

The nonvolatile fields are plain registers with parameterised reset values. The write-protect pin is level sensitive. It takes effect only when the protect-enable bit is 1.

Top module: `sprot_status_unit`

## Requirements
- R1: The status byte has this layout: bit 7 protect-enable, bits 6..4 read 0, bits 3..2 lock code, bit 1 enable latch, bit 0 busy. After reset the latch and the busy flag are 0, and the lock code and protect-enable hold their parameter reset values (default 0x00).
- R2: When the unit is idle, a set strobe makes the latch 1 and a clear strobe makes it 0. If both arrive in the same cycle, the clear wins.
- R3: An array request is granted only if the latch is 1, the unit is idle and the address is unlocked. The lock codes are: 00 locks nothing, 01 locks 0x3000–0x3FFF, 10 locks 0x2000–0x3FFF, 11 locks the whole array.
- R4: A denied array request raises only the deny pulse. The latch is unchanged and the busy flag stays 0.
- R5: The cycle after a grant, busy reads 1 and the status byte reads 0xFF. A done pulse returns busy to 0 and clears the latch.
- R6: Hardware protection is active when the pin is low and protect-enable is 1. A status commit made while it is active is denied. When protect-enable is 0, the pin level has no effect.
- R7: If hardware protection becomes active at any cycle while a status value is staged, the staged value is dropped. A later commit is then denied, even after the pin has returned high.
- R8: A completed status write changes only bits 7, 3 and 2, copying them from the staged byte. Staged bits 6..4 and 1..0 are ignored.
- R9: If an array request that qualifies and a status commit arrive in the same cycle, the array write is granted and the status commit is denied.
- R10: While busy, every commit request is denied. Latch strobes and staging strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_i | input | 1 | Set-latch strobe |
| wrdi_i | input | 1 | Clear-latch strobe |
| sr_load_i | input | 1 | Stage a status value |
| sr_data_i | input | 8 | Status value to stage |
| sr_commit_i | input | 1 | Request commit of the staged status value |
| arr_req_i | input | 1 | Request commit of an array write |
| arr_addr_i | input | ADDR_W | Address of the array write |
| wp_pin_i | input | 1 | Write-protect pin, low protects |
| wdone_i | input | 1 | Write timer finished |
| status_o | output | 8 | Status byte for reads |
| arr_grant_o | output | 1 | Array write granted |
| arr_deny_o | output | 1 | Array write denied |
| sr_grant_o | output | 1 | Status write granted |
| sr_deny_o | output | 1 | Status write denied |

## Verification
The collision that matters most is an array request and a status commit landing in the same cycle, while both would otherwise qualify. The bench stages a status value and then raises both strobes on the same edge. It expects an array grant and a status deny together. The busy window that follows must be the array write's, so the nonvolatile fields stay unchanged after done. A behavioural reference model runs beside the design and compares every output on every clock. Around it, directed sequences hit the lock boundaries, the pin cancelling a staged value, and strobes that arrive while busy.

// File: rtl/sprot_pkg.sv
package sprot_pkg;

    typedef enum logic {
        WK_ARRAY  = 1'b0,
        WK_STATUS = 1'b1
    } wkind_e;

    typedef enum logic [1:0] {
        LK_NONE = 2'b00,
        LK_QTR  = 2'b01,
        LK_HALF = 2'b10,
        LK_ALL  = 2'b11
    } lock_e;

    typedef struct packed {
        logic  wpen;
        lock_e lock;
    } nv_cfg_t;

    localparam logic [7:0] BUSY_BYTE = 8'hFF;

    function automatic logic [7:0] pack_status(nv_cfg_t cfg, logic wel, logic wip);
        logic [7:0] b;
        if (wip) begin
            b = BUSY_BYTE;
        end else begin
            b = {cfg.wpen, 3'b000, cfg.lock, wel, 1'b0};
        end
        return b;
    endfunction

endpackage

// File: rtl/sprot_region.sv
module sprot_region
    import sprot_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  lock_e             lock,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(2) << (ADDR_W - 2);

    always_comb begin
        unique case (lock)
            LK_NONE: locked = 1'b0;
            LK_QTR:  locked = (addr >= QTR_BASE);
            LK_HALF: locked = (addr >= HALF_BASE);
            LK_ALL:  locked = 1'b1;
            default: locked = 1'b1;
        endcase
    end

    always_comb begin
        if (lock == LK_NONE) begin
            a_none_free_r3: assert (!locked);
        end
        if (lock == LK_ALL) begin
            a_all_locked_r3: assert (locked);
        end
    end
endmodule

// File: rtl/sprot_wel.sv
module sprot_wel (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic busy_i,
    input  logic done_i,
    output logic wel_o
);
    logic wel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q <= 1'b0;
        end else if (busy_i) begin
            if (done_i) begin
                wel_q <= 1'b0;
            end
        end else if (clr_i) begin
            wel_q <= 1'b0;
        end else if (set_i) begin
            wel_q <= 1'b1;
        end
    end

    assign wel_o = wel_q;

    p_clear_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && clr_i) |=> !wel_o);
    p_set_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && set_i && !clr_i) |=> wel_o);
    p_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_i && done_i) |=> !wel_o);
endmodule

// File: rtl/sprot_busy.sv
module sprot_busy
    import sprot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_arr_i,
    input  logic   start_sr_i,
    input  logic   done_i,
    output logic   wip_o,
    output wkind_e kind_o
);
    logic   wip_q;
    wkind_e kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wip_q  <= 1'b0;
            kind_q <= WK_ARRAY;
        end else if (start_arr_i) begin
            wip_q  <= 1'b1;
            kind_q <= WK_ARRAY;
        end else if (start_sr_i) begin
            wip_q  <= 1'b1;
            kind_q <= WK_STATUS;
        end else if (done_i) begin
            wip_q  <= 1'b0;
        end
    end

    assign wip_o  = wip_q;
    assign kind_o = kind_q;

    p_single_start_r9: assert property (@(posedge clk) disable iff (rst)
        !(start_arr_i && start_sr_i));
    p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (start_arr_i || start_sr_i) |-> !wip_q);
    p_done_ends_r5: assert property (@(posedge clk) disable iff (rst)
        (wip_q && done_i) |=> !wip_q);
endmodule

// File: rtl/sprot_stage.sv
module sprot_stage
    import sprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] data_i,
    input  logic       commit_i,
    input  logic       busy_i,
    input  logic       hwprot_i,
    output logic       pend_o,
    output nv_cfg_t    staged_o
);
    logic    pend_q;
    nv_cfg_t staged_q;
    logic    stray_unused;

    assign stray_unused = ^{data_i[6:4], data_i[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            staged_q <= '0;
        end else begin
            if (load_i && !busy_i) begin
                pend_q   <= 1'b1;
                staged_q <= '{wpen: data_i[7], lock: lock_e'(data_i[3:2])};
            end
            if (commit_i || hwprot_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pend_o   = pend_q;
    assign staged_o = staged_q;

    p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        hwprot_i |=> !pend_q);
    p_busy_ignore_load_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !load_i) |=> $stable(staged_q));
endmodule

// File: rtl/sprot_status_unit.sv
module sprot_status_unit
    import sprot_pkg::*;
#(
    parameter int          ADDR_W   = 14,
    parameter logic        RST_WPEN = 1'b0,
    parameter logic [1:0]  RST_LOCK = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              sr_load_i,
    input  logic [7:0]        sr_data_i,
    input  logic              sr_commit_i,
    input  logic              arr_req_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              wp_pin_i,
    input  logic              wdone_i,
    output logic [7:0]        status_o,
    output logic              arr_grant_o,
    output logic              arr_deny_o,
    output logic              sr_grant_o,
    output logic              sr_deny_o
);
    nv_cfg_t cfg_q;
    nv_cfg_t staged;
    wkind_e  kind;
    logic    wel, wip, pend, locked, hwprot;
    logic    arr_ok, sr_ok, done_ok;
    logic    ag_q, ad_q, sg_q, sd_q;

    assign hwprot  = cfg_q.wpen & ~wp_pin_i;
    assign done_ok = wdone_i & wip;
    assign arr_ok  = arr_req_i & ~wip & wel & ~locked;
    assign sr_ok   = sr_commit_i & ~wip & ~arr_ok & pend & wel & ~hwprot;

    sprot_region #(.ADDR_W(ADDR_W)) region_i (
        .lock   (cfg_q.lock),
        .addr   (arr_addr_i),
        .locked (locked)
    );

    sprot_wel wel_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (wren_i),
        .clr_i  (wrdi_i),
        .busy_i (wip),
        .done_i (wdone_i),
        .wel_o  (wel)
    );

    sprot_busy busy_i (
        .clk         (clk),
        .rst         (rst),
        .start_arr_i (arr_ok),
        .start_sr_i  (sr_ok),
        .done_i      (done_ok),
        .wip_o       (wip),
        .kind_o      (kind)
    );

    sprot_stage stage_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (sr_load_i),
        .data_i   (sr_data_i),
        .commit_i (sr_commit_i),
        .busy_i   (wip),
        .hwprot_i (hwprot),
        .pend_o   (pend),
        .staged_o (staged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{wpen: RST_WPEN, lock: lock_e'(RST_LOCK)};
        end else if (done_ok && kind == WK_STATUS) begin
            cfg_q <= staged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ag_q <= 1'b0;
            ad_q <= 1'b0;
            sg_q <= 1'b0;
            sd_q <= 1'b0;
        end else begin
            ag_q <= arr_ok;
            ad_q <= arr_req_i & ~arr_ok;
            sg_q <= sr_ok;
            sd_q <= sr_commit_i & ~sr_ok;
        end
    end

    assign status_o    = pack_status(cfg_q, wel, wip);
    assign arr_grant_o = ag_q;
    assign arr_deny_o  = ad_q;
    assign sr_grant_o  = sg_q;
    assign sr_deny_o   = sd_q;

    p_arr_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(arr_grant_o && arr_deny_o));
    p_deny_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (arr_deny_o && !sr_grant_o && !$past(wip)) |-> !wip);
    p_busy_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> (arr_grant_o || sr_grant_o));
    p_sr_hwprot_r6: assert property (@(posedge clk) disable iff (rst)
        sr_grant_o |-> !$past(cfg_q.wpen && !wp_pin_i));
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(wdone_i) |-> $stable(cfg_q));
    p_collide_r9: assert property (@(posedge clk) disable iff (rst)
        (arr_ok && sr_commit_i) |=> sr_deny_o);
endmodule

// File: tb/sprot_status_unit_tb_top.sv
`timescale 1ns/1ps
module sprot_status_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wren_i = 0, wrdi_i = 0, sr_load_i = 0, sr_commit_i = 0, arr_req_i = 0;
    logic [7:0]  sr_data_i = 0;
    logic [13:0] arr_addr_i = 0;
    logic        wp_pin_i = 1'b1, wdone_i = 0;
    logic [7:0]  status_o;
    logic        arr_grant_o, arr_deny_o, sr_grant_o, sr_deny_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    sprot_status_unit dut_i (
        .clk(clk), .rst(rst), .wren_i(wren_i), .wrdi_i(wrdi_i),
        .sr_load_i(sr_load_i), .sr_data_i(sr_data_i), .sr_commit_i(sr_commit_i),
        .arr_req_i(arr_req_i), .arr_addr_i(arr_addr_i), .wp_pin_i(wp_pin_i),
        .wdone_i(wdone_i), .status_o(status_o), .arr_grant_o(arr_grant_o),
        .arr_deny_o(arr_deny_o), .sr_grant_o(sr_grant_o), .sr_deny_o(sr_deny_o)
    );

    // behavioural reference model
    int m_wel, m_wip, m_wpen, m_lock, m_pend, m_pdata, m_kind_sr;
    int m_ag, m_ad, m_sg, m_sd;

    function automatic int m_locked(int addr, int lk);
        if (lk == 1) return (addr >= 12288) ? 1 : 0;
        if (lk == 2) return (addr >= 8192) ? 1 : 0;
        if (lk == 3) return 1;
        return 0;
    endfunction

    function automatic int m_status();
        if (m_wip != 0) return 255;
        return m_wpen * 128 + m_lock * 4 + m_wel * 2;
    endfunction

    always @(posedge clk) begin
        int hw, ag, sg, pn;
        if (rst) begin
            m_wel = 0; m_wip = 0; m_wpen = 0; m_lock = 0; m_pend = 0; m_pdata = 0;
            m_kind_sr = 0; m_ag = 0; m_ad = 0; m_sg = 0; m_sd = 0;
        end else begin
            hw = (m_wpen != 0 && wp_pin_i == 1'b0) ? 1 : 0;
            ag = (arr_req_i && m_wip == 0 && m_wel == 1 && m_locked(int'(arr_addr_i), m_lock) == 0) ? 1 : 0;
            sg = (sr_commit_i && m_wip == 0 && ag == 0 && m_pend == 1 && m_wel == 1 && hw == 0) ? 1 : 0;
            m_ag = ag; m_ad = (arr_req_i && ag == 0) ? 1 : 0;
            m_sg = sg; m_sd = (sr_commit_i && sg == 0) ? 1 : 0;
            pn = m_pend;
            if (sr_load_i && m_wip == 0) begin pn = 1; m_pdata = int'(sr_data_i); end
            if (sr_commit_i || hw == 1) pn = 0;
            if (m_wip == 1) begin
                if (wdone_i) begin
                    m_wel = 0; m_wip = 0;
                    if (m_kind_sr == 1) begin
                        m_wpen = (m_pdata >> 7) & 1;
                        m_lock = (m_pdata >> 2) & 3;
                    end
                end
            end else begin
                if (wrdi_i) m_wel = 0;
                else if (wren_i) m_wel = 1;
                if (ag == 1) begin m_wip = 1; m_kind_sr = 0; end
                else if (sg == 1) begin m_wip = 1; m_kind_sr = 1; end
            end
            m_pend = pn;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            checks++;
            if (int'(status_o) != m_status()) begin
                errors++;
                $display("FAIL R1 model status actual %02h expected %02h", status_o, m_status());
            end
            checks++;
            if (int'(arr_grant_o) != m_ag || int'(arr_deny_o) != m_ad) begin
                errors++;
                $display("FAIL R3 model array g/d actual %0d%0d expected %0d%0d",
                         arr_grant_o, arr_deny_o, m_ag, m_ad);
            end
            checks++;
            if (int'(sr_grant_o) != m_sg || int'(sr_deny_o) != m_sd) begin
                errors++;
                $display("FAIL R6 model status g/d actual %0d%0d expected %0d%0d",
                         sr_grant_o, sr_deny_o, m_sg, m_sd);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        wren_i = 0; wrdi_i = 0; sr_load_i = 0; sr_commit_i = 0; arr_req_i = 0; wdone_i = 0;
    endtask

    task automatic finish_write();
        tick(); tick();
        wdone_i = 1; tick();
    endtask

    task automatic arr(int a);
        arr_addr_i = 14'(a); arr_req_i = 1; tick();
    endtask

    task automatic stage(int d);
        sr_data_i = 8'(d); sr_load_i = 1; tick();
    endtask

    task automatic commit();
        sr_commit_i = 1; tick();
    endtask

    task automatic set_wel();
        wren_i = 1; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        tick();
        chk("R1 reset status", status_o, 8'h00);
        set_wel();
        chk("R2 set latch", status_o, 8'h02);
        wren_i = 1; wrdi_i = 1; tick();
        chk("R2 clear wins", status_o, 8'h00);
        set_wel();
        arr(16'h0100);
        chk("R3 grant unlocked", arr_grant_o, 1);
        chk("R5 busy byte", status_o, 8'hFF);
        arr(16'h0200);
        chk("R10 deny while busy", arr_deny_o, 1);
        stage(8'h80);
        wdone_i = 1; tick();
        chk("R5 done clears", status_o, 8'h00);
        set_wel();
        commit();
        chk("R10 stage ignored while busy", sr_deny_o, 1);
        arr(16'h0100);
        chk("R3 grant unlocked again", arr_grant_o, 1);
        wdone_i = 1; tick();
        arr(16'h0100);
        chk("R4 deny no latch", arr_deny_o, 1);
        chk("R4 idle after deny", status_o, 8'h00);
        set_wel();
        stage(8'hFF);
        commit();
        chk("R8 status grant", sr_grant_o, 1);
        finish_write();
        chk("R8 only 7,3,2 change", status_o, 8'h8C);
        wp_pin_i = 0;
        set_wel();
        arr(16'h0000);
        chk("R3 all locked", arr_deny_o, 1);
        chk("R4 latch kept", status_o, 8'h8E);
        stage(8'h00);
        commit();
        chk("R6 protected commit denied", sr_deny_o, 1);
        chk("R6 status unchanged", status_o, 8'h8E);
        wp_pin_i = 1;
        stage(8'h84);
        commit();
        chk("R6 pin high grant", sr_grant_o, 1);
        finish_write();
        chk("R8 quarter lock", status_o, 8'h84);
        set_wel();
        arr(16'h3000);
        chk("R3 quarter edge locked", arr_deny_o, 1);
        arr(16'h2FFF);
        chk("R3 below quarter granted", arr_grant_o, 1);
        finish_write();
        set_wel();
        stage(8'h88);
        wp_pin_i = 0; tick();
        wp_pin_i = 1; tick();
        commit();
        chk("R7 cancelled stage", sr_deny_o, 1);
        chk("R7 cfg unchanged", status_o, 8'h86);
        stage(8'h80);
        arr_addr_i = 14'h0010; arr_req_i = 1; sr_commit_i = 1; tick();
        chk("R9 array wins", arr_grant_o, 1);
        chk("R9 status loses", sr_deny_o, 1);
        finish_write();
        chk("R9 cfg kept", status_o, 8'h84);
        set_wel();
        stage(8'h00);
        commit();
        finish_write();
        chk("R8 clear protect", status_o, 8'h00);
        wp_pin_i = 0;
        set_wel();
        stage(8'h08);
        commit();
        chk("R6 pin ignored wpen0", sr_grant_o, 1);
        finish_write();
        chk("R6 half lock set", status_o, 8'h08);
        wp_pin_i = 1;
        set_wel();
        arr(16'h2000);
        chk("R3 half edge locked", arr_deny_o, 1);
        arr(16'h1FFF);
        chk("R3 below half granted", arr_grant_o, 1);
        finish_write();
        tick();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule